// File: doc/BRIEF.md
# Circular Halfword DMA Channel

This block is one DMA channel that carries 16-bit samples from a peripheral into a buffer in memory. The peripheral raises a request line whenever it has a sample ready. The channel takes exactly one halfword for each request it accepts and returns a one-cycle acknowledge. It then writes the halfword to memory. The source address never changes: it is the peripheral's data register and is presented on `per_addr`. The destination pointer starts at a programmed base and advances by two bytes for each item.

Software sets the source, the base, the item count and a control word, then enables the channel. In normal mode the channel stops and drops its enable once the count is used up. In circular mode the pointer returns to the base and the count reloads, so the buffer refills forever. A half-transfer flag and a transfer-complete flag let software work on one half of the buffer while the other half fills. Both flags are sticky and can drive a gated interrupt.

On the memory side, `mem_valid`/`mem_ready` is a valid/ready handshake. Once `mem_valid` rises, it stays high with `mem_addr` and `mem_data` frozen until a cycle in which `mem_ready` is high. While that write waits, no new request is accepted, so stalls push back onto the peripheral through a missing acknowledge. A requester holds `per_req` until it sees `per_ack` and drops it in the following cycle.

Top module: `circdma_engine`

## Requirements
- R1: After reset, `ch_en`, `mem_valid`, `per_ack`, `ht_flag`, `tc_flag` and `irq` are 0 and `rem_count` is 0.
- R2: When the channel is enabled, no write is pending and `rem_count` is nonzero, a request is accepted at a clock edge. `per_ack` is then high for exactly the next cycle, `mem_valid` rises in that same cycle, and `mem_data` carries the `per_data` sampled at the accepting edge. `per_addr` always shows the programmed source address.
- R3: The first item goes to the base address. Each later item goes to the previous address plus 2.
- R4: While `mem_valid` is high and `mem_ready` is low, `mem_valid`, `mem_addr`, `mem_data` and `rem_count` hold, and no request is acknowledged.
- R5: In normal mode (control bit 1 = 0), the write of the last counted item clears `ch_en` and leaves `rem_count` at 0. Later requests get no acknowledge.
- R6: In circular mode (control bit 1 = 1), the write of the last item reloads `rem_count` to the count and returns the pointer to the base. `ch_en` stays 1.
- R7: `ht_flag` sets on the write that brings the number of items in the current pass to floor(count/2). It never sets when that value is 0.
- R8: `tc_flag` sets on the write of the last item of each pass.
- R9: The flags stay set until `ht_clr`/`tc_clr` is pulsed. A set in the same cycle as a clear wins.
- R10: `irq` = (`ht_flag` AND control bit 2) OR (`tc_flag` AND control bit 3).
- R11: While `ch_en` is 1, writes to the source (`cfg_addr`=0), base (1) and count (2) registers are ignored. A control write (3) only acts through bit 0: writing 0 there disables the channel, and the mode and enable bits keep their values.
- R12: A control write that sets bit 0 while the stored count is 0 leaves the channel disabled.
- R13: `rem_count` always shows the items left in the current pass, and it loads the count when the channel is enabled.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| cfg_wr | input | 1 | Configuration write strobe |
| cfg_addr | input | 2 | Register select: 0 source, 1 base, 2 count, 3 control |
| cfg_wdata | input | 32 | Write data |
| per_addr | output | ADDR_W | Fixed source address presented to the peripheral |
| per_req | input | 1 | Peripheral sample request |
| per_data | input | 16 | Peripheral sample |
| per_ack | output | 1 | One-cycle acknowledge per accepted request |
| mem_valid | output | 1 | Memory write valid |
| mem_ready | input | 1 | Memory write ready |
| mem_addr | output | ADDR_W | Memory byte address |
| mem_data | output | 16 | Memory write data |
| rem_count | output | CNT_W | Items left in the current pass |
| ch_en | output | 1 | Channel enabled |
| ht_flag | output | 1 | Sticky half-transfer flag |
| tc_flag | output | 1 | Sticky transfer-complete flag |
| ht_clr | input | 1 | Clear half-transfer flag |
| tc_clr | input | 1 | Clear transfer-complete flag |
| irq | output | 1 | Gated interrupt |

## Verification
A pointer that drifts shows as a wrong `mem_addr` on the very next write. A miscounted `rem_count` shows right away on its own port, and at the end of a pass it makes the flags land early or late, or keeps the channel running past the count. A stuck pending-write state shows within one cycle, either as a missing acknowledge or as two acknowledges inside one stalled write. The tests use even and odd counts, several circular wraps and a held-off memory, so that each of these faults is seen at the ports within a few items.

// File: rtl/dma_pkg.sv
package dma_pkg;
  typedef enum logic [1:0] {
    REG_SRC = 2'd0,
    REG_DST = 2'd1,
    REG_CNT = 2'd2,
    REG_CTL = 2'd3
  } cfg_reg_e;

  localparam int CTL_EN    = 0;
  localparam int CTL_CIRC  = 1;
  localparam int CTL_HT_IE = 2;
  localparam int CTL_TC_IE = 3;
  localparam int CFG_W     = 32;
endpackage

// File: rtl/dma_cfg_regs.sv
module dma_cfg_regs
  import dma_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int CNT_W  = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_wr,
  input  logic [1:0]        cfg_addr,
  input  logic [CFG_W-1:0]  cfg_wdata,
  input  logic              done,
  output logic [ADDR_W-1:0] src_addr,
  output logic [ADDR_W-1:0] dst_base,
  output logic [CNT_W-1:0]  count_cfg,
  output logic              en,
  output logic              circ,
  output logic              ht_ie,
  output logic              tc_ie,
  output logic              start
);
  logic wr_ctl;
  logic unused_cfg;

  assign unused_cfg = ^cfg_wdata;
  assign wr_ctl = cfg_wr && (cfg_reg_e'(cfg_addr) == REG_CTL);
  assign start  = wr_ctl && cfg_wdata[CTL_EN] && !en && (count_cfg != '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      src_addr  <= '0;
      dst_base  <= '0;
      count_cfg <= '0;
      circ      <= 1'b0;
      ht_ie     <= 1'b0;
      tc_ie     <= 1'b0;
      en        <= 1'b0;
    end else begin
      if (cfg_wr && !en) begin
        case (cfg_reg_e'(cfg_addr))
          REG_SRC: src_addr  <= cfg_wdata[ADDR_W-1:0];
          REG_DST: dst_base  <= cfg_wdata[ADDR_W-1:0];
          REG_CNT: count_cfg <= cfg_wdata[CNT_W-1:0];
          REG_CTL: begin
            circ  <= cfg_wdata[CTL_CIRC];
            ht_ie <= cfg_wdata[CTL_HT_IE];
            tc_ie <= cfg_wdata[CTL_TC_IE];
          end
          default: ;
        endcase
      end
      if (done)        en <= 1'b0;
      else if (wr_ctl) en <= en ? cfg_wdata[CTL_EN] : start;
    end
  end

  // R5: finishing a normal-mode pass drops the enable
  assert_done_stops_R5: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !en);
  // R11: the address and count registers are frozen while enabled
  assert_cfg_locked_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (en && cfg_wr && cfg_reg_e'(cfg_addr) != REG_CTL) |=>
      ($stable(src_addr) && $stable(dst_base) && $stable(count_cfg)));
  // R12: a zero count cannot enable the channel
  assert_zero_count_R12: assert property (@(posedge clk) disable iff (!rst_n)
    (!en && count_cfg == '0 && !(cfg_wr && cfg_reg_e'(cfg_addr) == REG_CNT)) |=> !en);
endmodule

// File: rtl/dma_xfer_ctl.sv
module dma_xfer_ctl #(
  parameter int ADDR_W = 32,
  parameter int CNT_W  = 16,
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              en,
  input  logic              circ,
  input  logic              start,
  input  logic [ADDR_W-1:0] dst_base,
  input  logic [CNT_W-1:0]  count_cfg,
  input  logic              per_req,
  input  logic [DATA_W-1:0] per_data,
  output logic              per_ack,
  output logic              mem_valid,
  input  logic              mem_ready,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [DATA_W-1:0] mem_data,
  output logic [CNT_W-1:0]  rem_count,
  output logic              ev_ht,
  output logic              ev_tc,
  output logic              done
);
  localparam int            STEP_BYTES = DATA_W / 8;
  localparam logic [ADDR_W-1:0] ADDR_STEP = ADDR_W'(STEP_BYTES);

  logic [ADDR_W-1:0] ptr;
  logic [CNT_W-1:0]  rem;
  logic [DATA_W-1:0] hold;
  logic              pend;
  logic              accept;
  logic              hs;
  logic              last;
  logic [CNT_W-1:0]  half;

  assign half   = count_cfg >> 1;
  assign accept = en && per_req && !pend && (rem != '0);
  assign hs     = pend && mem_ready;
  assign last   = hs && (rem == CNT_W'(1));
  assign ev_tc  = last;
  assign ev_ht  = hs && (half != '0) && (rem == count_cfg - half + CNT_W'(1));
  assign done   = last && !circ;

  assign mem_valid = pend;
  assign mem_addr  = ptr;
  assign mem_data  = hold;
  assign rem_count = rem;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ptr     <= '0;
      rem     <= '0;
      hold    <= '0;
      pend    <= 1'b0;
      per_ack <= 1'b0;
    end else begin
      per_ack <= accept;
      if (accept) begin
        pend <= 1'b1;
        hold <= per_data;
      end else if (hs) begin
        pend <= 1'b0;
      end
      if (start) begin
        ptr <= dst_base;
        rem <= count_cfg;
      end else if (hs) begin
        if (last && circ) begin
          ptr <= dst_base;
          rem <= count_cfg;
        end else begin
          ptr <= ptr + ADDR_STEP;
          rem <= rem - CNT_W'(1);
        end
      end
    end
  end

  // R2: an acknowledge comes with the write of the sample taken at acceptance
  assert_ack_write_R2: assert property (@(posedge clk) disable iff (!rst_n)
    per_ack |-> (mem_valid && mem_data == $past(per_data)));
  // R4: a stalled write keeps its address, data and count
  assert_stall_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_valid && !mem_ready) |=>
      (mem_valid && $stable(mem_addr) && $stable(mem_data) && $stable(rem_count)));
  // R5: no acknowledge unless the channel was enabled
  assert_ack_needs_en_R5: assert property (@(posedge clk) disable iff (!rst_n)
    per_ack |-> $past(en));
  // R13: the remaining count never exceeds the programmed count while running
  assert_rem_bound_R13: assert property (@(posedge clk) disable iff (!rst_n)
    en |-> (rem_count <= count_cfg));
endmodule

// File: rtl/dma_irq_flags.sv
module dma_irq_flags (
  input  logic clk,
  input  logic rst_n,
  input  logic ev_ht,
  input  logic ev_tc,
  input  logic ht_clr,
  input  logic tc_clr,
  input  logic ht_ie,
  input  logic tc_ie,
  output logic ht_flag,
  output logic tc_flag,
  output logic irq
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ht_flag <= 1'b0;
      tc_flag <= 1'b0;
    end else begin
      if (ev_ht)       ht_flag <= 1'b1;
      else if (ht_clr) ht_flag <= 1'b0;
      if (ev_tc)       tc_flag <= 1'b1;
      else if (tc_clr) tc_flag <= 1'b0;
    end
  end

  assign irq = (ht_flag && ht_ie) || (tc_flag && tc_ie);

  // R9: a flag only drops through its clear input
  assert_ht_sticky_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (ht_flag && !ht_clr) |=> ht_flag);
  assert_tc_sticky_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (tc_flag && !tc_clr) |=> tc_flag);
  // R8: a completion event is always visible afterwards
  assert_tc_set_R8: assert property (@(posedge clk) disable iff (!rst_n)
    ev_tc |=> tc_flag);
endmodule

// File: rtl/circdma_engine.sv
module circdma_engine
  import dma_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int CNT_W  = 16,
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_wr,
  input  logic [1:0]        cfg_addr,
  input  logic [CFG_W-1:0]  cfg_wdata,
  output logic [ADDR_W-1:0] per_addr,
  input  logic              per_req,
  input  logic [DATA_W-1:0] per_data,
  output logic              per_ack,
  output logic              mem_valid,
  input  logic              mem_ready,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [DATA_W-1:0] mem_data,
  output logic [CNT_W-1:0]  rem_count,
  output logic              ch_en,
  output logic              ht_flag,
  output logic              tc_flag,
  input  logic              ht_clr,
  input  logic              tc_clr,
  output logic              irq
);
  logic [ADDR_W-1:0] dst_base;
  logic [CNT_W-1:0]  count_cfg;
  logic circ, ht_ie, tc_ie, start, done, ev_ht, ev_tc;

  dma_cfg_regs #(.ADDR_W(ADDR_W), .CNT_W(CNT_W)) u_cfg (
    .clk(clk), .rst_n(rst_n), .cfg_wr(cfg_wr), .cfg_addr(cfg_addr),
    .cfg_wdata(cfg_wdata), .done(done), .src_addr(per_addr),
    .dst_base(dst_base), .count_cfg(count_cfg), .en(ch_en), .circ(circ),
    .ht_ie(ht_ie), .tc_ie(tc_ie), .start(start)
  );

  dma_xfer_ctl #(.ADDR_W(ADDR_W), .CNT_W(CNT_W), .DATA_W(DATA_W)) u_xfer (
    .clk(clk), .rst_n(rst_n), .en(ch_en), .circ(circ), .start(start),
    .dst_base(dst_base), .count_cfg(count_cfg), .per_req(per_req),
    .per_data(per_data), .per_ack(per_ack), .mem_valid(mem_valid),
    .mem_ready(mem_ready), .mem_addr(mem_addr), .mem_data(mem_data),
    .rem_count(rem_count), .ev_ht(ev_ht), .ev_tc(ev_tc), .done(done)
  );

  dma_irq_flags u_flags (
    .clk(clk), .rst_n(rst_n), .ev_ht(ev_ht), .ev_tc(ev_tc),
    .ht_clr(ht_clr), .tc_clr(tc_clr), .ht_ie(ht_ie), .tc_ie(tc_ie),
    .ht_flag(ht_flag), .tc_flag(tc_flag), .irq(irq)
  );

  // R2: the acknowledge is a single-cycle pulse
  assert_ack_pulse_R2: assert property (@(posedge clk) disable iff (!rst_n)
    per_ack |=> !per_ack);
  // R6: circular mode never drops the enable by itself
  assert_circ_runs_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (ch_en && circ && !cfg_wr) |=> ch_en);
endmodule

// File: tb/circdma_engine_tb_top.sv
module circdma_engine_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_wr = 1'b0;
  logic [1:0]  cfg_addr = '0;
  logic [31:0] cfg_wdata = '0;
  logic [31:0] per_addr;
  logic        per_req = 1'b0;
  logic [15:0] per_data = '0;
  logic        per_ack, mem_valid;
  logic        mem_ready = 1'b1;
  logic [31:0] mem_addr;
  logic [15:0] mem_data;
  logic [15:0] rem_count;
  logic        ch_en, ht_flag, tc_flag, irq;
  logic        ht_clr = 1'b0, tc_clr = 1'b0;
  int checks = 0, failures = 0;
  bit finished = 0;

  always #2 clk = ~clk;

  circdma_engine dut_i (
    .clk(clk), .rst_n(rst_n), .cfg_wr(cfg_wr), .cfg_addr(cfg_addr),
    .cfg_wdata(cfg_wdata), .per_addr(per_addr), .per_req(per_req),
    .per_data(per_data), .per_ack(per_ack), .mem_valid(mem_valid),
    .mem_ready(mem_ready), .mem_addr(mem_addr), .mem_data(mem_data),
    .rem_count(rem_count), .ch_en(ch_en), .ht_flag(ht_flag),
    .tc_flag(tc_flag), .ht_clr(ht_clr), .tc_clr(tc_clr), .irq(irq)
  );

  task automatic check(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic cfg(input logic [1:0] a, input logic [31:0] d);
    cfg_wr = 1'b1; cfg_addr = a; cfg_wdata = d;
    @(negedge clk);
    cfg_wr = 1'b0;
  endtask

  task automatic clear_flags();
    ht_clr = 1'b1; tc_clr = 1'b1;
    @(negedge clk);
    ht_clr = 1'b0; tc_clr = 1'b0;
  endtask

  // one item with memory ready: checks ack, address and data (R2, R3)
  task automatic push(input logic [15:0] d, input logic [31:0] exp_addr);
    per_data = d; per_req = 1'b1;
    @(negedge clk);
    check(per_ack && mem_valid, "R2 ack", {per_ack, mem_valid}, 2'b11);
    check(mem_addr == exp_addr, "R3 addr", mem_addr, exp_addr);
    check(mem_data == d, "R2 data", mem_data, d);
    per_req = 1'b0;
    @(negedge clk);
    check(!mem_valid && !per_ack, "R2 single", {per_ack, mem_valid}, 0);
  endtask

  task automatic expect_no_ack(input string req);
    bit seen = 0;
    per_req = 1'b1;
    for (int i = 0; i < 4; i++) begin
      @(negedge clk);
      if (per_ack || mem_valid) seen = 1;
    end
    per_req = 1'b0;
    check(!seen, req, seen, 0);
  endtask

  task automatic t_reset();
    check({ch_en, mem_valid, per_ack, ht_flag, tc_flag, irq} == 0 && rem_count == 0,
          "R1 reset", {ch_en, mem_valid, per_ack, ht_flag, tc_flag, irq, rem_count}, 0);
  endtask

  task automatic t_normal();
    cfg(0, 32'h4001_244C); cfg(1, 32'h2000_0100); cfg(2, 4); cfg(3, 32'h1);
    check(per_addr == 32'h4001_244C, "R2 per_addr", per_addr, 32'h4001_244C);
    check(rem_count == 4, "R13 load", rem_count, 4);
    push(16'h0A11, 32'h2000_0100);
    check(!ht_flag, "R7 early", ht_flag, 0);
    push(16'h0A22, 32'h2000_0102);
    check(ht_flag && !tc_flag && rem_count == 2, "R7 half", {ht_flag, tc_flag, rem_count}, {2'b10, 16'd2});
    push(16'h0A33, 32'h2000_0104);
    push(16'h0A44, 32'h2000_0106);
    check(tc_flag && !ch_en && rem_count == 0, "R5 stop", {tc_flag, ch_en, rem_count}, {2'b10, 16'd0});
    check(!irq, "R10 gated off", irq, 0);
    expect_no_ack("R5 no ack after stop");
    clear_flags();
    check(!ht_flag && !tc_flag, "R9 clear", {ht_flag, tc_flag}, 0);
  endtask

  task automatic t_circ();
    logic [31:0] base = 32'h2000_0200;
    cfg(1, base); cfg(2, 3); cfg(3, 32'hF);
    for (int i = 0; i < 7; i++) begin
      push(16'h1000 + 16'(i), base + 32'((i % 3) * 2));
      if (i == 0) begin
        check(ht_flag && irq, "R7 odd half", {ht_flag, irq}, 2'b11);
        ht_clr = 1'b1; @(negedge clk); ht_clr = 1'b0;
        check(!irq, "R10 irq clears", irq, 0);
      end
      if (i == 2) begin
        check(tc_flag && ch_en && rem_count == 3, "R6 wrap", {tc_flag, ch_en, rem_count}, {2'b11, 16'd3});
        check(!ht_flag, "R7 once per pass", ht_flag, 0);
        tc_clr = 1'b1; @(negedge clk); tc_clr = 1'b0;
      end
      if (i == 3) check(ht_flag && !tc_flag, "R8 second pass", {ht_flag, tc_flag}, 2'b10);
    end
    check(rem_count == 2, "R13 mid pass", rem_count, 2);
    cfg(3, 32'h0);
    check(!ch_en, "R11 disable", ch_en, 0);
    clear_flags();
  endtask

  task automatic t_backpressure();
    logic [31:0] a0;
    cfg(1, 32'h2000_0300); cfg(2, 2); cfg(3, 32'h1);
    mem_ready = 1'b0; per_data = 16'hBEEF; per_req = 1'b1;
    @(negedge clk);
    check(per_ack && mem_valid, "R2 stalled ack", {per_ack, mem_valid}, 2'b11);
    a0 = mem_addr; per_req = 1'b0;
    @(negedge clk);
    per_data = 16'h5555; per_req = 1'b1;
    for (int i = 0; i < 3; i++) begin
      @(negedge clk);
      check(mem_valid && !per_ack && mem_addr == a0 && mem_data == 16'hBEEF && rem_count == 2,
            "R4 hold", {mem_valid, per_ack, mem_data, rem_count}, {2'b10, 16'hBEEF, 16'd2});
    end
    per_req = 1'b0; mem_ready = 1'b1;
    @(negedge clk);
    check(!mem_valid && rem_count == 1, "R4 release", {mem_valid, rem_count}, {1'b0, 16'd1});
    push(16'h7777, 32'h2000_0302);
    clear_flags();
  endtask

  task automatic t_locked();
    cfg(1, 32'h2000_0400); cfg(2, 2); cfg(3, 32'h1);
    cfg(1, 32'h2000_0800); cfg(2, 9); cfg(3, 32'h3);
    check(rem_count == 2 && ch_en, "R11 locked", rem_count, 2);
    push(16'h0001, 32'h2000_0400);
    push(16'h0002, 32'h2000_0402);
    check(!ch_en && rem_count == 0, "R11 mode kept normal", {ch_en, rem_count}, 0);
    clear_flags();
  endtask

  task automatic t_zero();
    cfg(2, 0); cfg(3, 32'h1);
    check(!ch_en, "R12 zero count", ch_en, 0);
    expect_no_ack("R12 no transfer");
  endtask

  task automatic t_setwins();
    cfg(1, 32'h2000_0500); cfg(2, 2); cfg(3, 32'h3);
    per_data = 16'h00C3; per_req = 1'b1;
    @(negedge clk);
    per_req = 1'b0; ht_clr = 1'b1;
    @(negedge clk);
    ht_clr = 1'b0;
    check(ht_flag, "R9 set wins", ht_flag, 1);
    cfg(3, 32'h0);
    clear_flags();
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    @(negedge clk);
    t_normal();
    t_circ();
    t_backpressure();
    t_locked();
    t_zero();
    t_setwins();
    finished = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      failures++;
      $display("FAIL watchdog actual=timeout expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule